// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit fully differential successive-approximation converter. The converter's DAC combines a tapped resistor string with a split capacitor array. A single start pulse launches a frame of twelve conversion slots. The first slot is reserved for comparator offset cancellation and the second for sampling the input. The ten remaining slots each resolve one bit, MSB (the sign bit) first. Every slot spans `SUB` cycles of the block clock. The block uses those cycles to time the comparator:

- a preamplify window over the first three quarters of the slot;
- a latch window over the last quarter;
- a one-cycle reset pulse on the final cycle.

From the slot and the bits already decided, the block drives registered gate enables for the analog switches:

- an input-sampling enable;
- a DAC-connect enable;
- a 6-bit coarse tap code for the resistor string (the negative half uses its complement);
- two one-hot fine selectors for the left and right capacitor-array halves.

The fine selectors resolve the last four bits asymmetrically. The first fine step moves both halves. After that, the left and right halves take turns, and each move depends on earlier decisions.

Every pin is plain control or status. There is no data stream, so no valid/ready handshake and no back-pressure. The result is a register that stays valid until the next accepted start. A one-cycle done pulse marks the end of each frame.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After an accepted start, `phase` is one-hot. Bit k is high for exactly SUB consecutive cycles, for k = 0..11 in order. After slot 11, `phase` is zero.
- R2: While idle and in slots 0 and 1, `coarse_tap` is 32 (mid-scale). `fine_l` is 7'b0000010 (index 1, offset 0) and `fine_r` is 4'b0001 (index 0, offset 0). `samp_en` is high during all of slot 1 and at no other time.
- R3: `samp_en` falls when slot 2 begins. `dac_en` rises one cycle later and stays high through the end of slot 11. The two are never high together.
- R4: In decision slot 2+j, for j = 0..5, `coarse_tap` holds the bits already resolved above position 5-j. Bit 5-j is set and the bits below it are zero. So the sign trial is 32, and the second trial is 48 when the sign bit is 1 and 16 when it is 0. For j of 6 or more, `coarse_tap` equals result[9:4].
- R5: Fine tap offsets are as follows. `fine_l` indices 0..6 mean -1, 0, +1, +4, +7, +8, +9. `fine_r` indices 0..3 mean 0, -2, -4, -6. The trial level is 16*coarse_tap + left offset - right offset. For bit 6 (slot 8), `fine_l` selects index 3 and `fine_r` selects index 2.
- R6: For bit 7 (slot 9), only the left half changes. `fine_l` selects index 5 if result[3]=1, else index 1. `fine_r` stays at index 2.
- R7: For bit 8 (slot 10), only the right half changes. `fine_r` selects index 3 if result[2]=1, else index 1.
- R8: For bit 9 (slot 11), only the left half changes. `fine_l` selects index 4*result[3] + 2*result[1]. `fine_r` is unchanged.
- R9: In decision slots, `preamp` is high in ticks 0..3*SUB/4-1 and `latch` is high in the remaining ticks. `cmp_rst` is high only on tick SUB-1. All three are low in slots 0 and 1 and while idle.
- R10: `result` is cleared on an accepted start. At the end of the last tick of slot 2+j, `cmp` is stored into result[9-j]. With `cmp` = 1 meaning input ≥ trial level, the final result equals the input code.
- R11: `done` is high for exactly one cycle, beginning SUB*12 cycles after the start edge. `result` then holds until the next accepted start.
- R12: A start while a frame runs is ignored, including in the frame's final cycle. A start during the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (sampled when idle) |
| cmp | input | 1 | Comparator decision, 1 = input at or above trial |
| phase | output | 12 | One-hot slot strobes |
| preamp | output | 1 | Comparator preamplify window |
| latch | output | 1 | Comparator latch window |
| cmp_rst | output | 1 | Comparator reset pulse |
| samp_en | output | 1 | Input sampling switches |
| dac_en | output | 1 | DAC taps connected to capacitor array |
| coarse_tap | output | 6 | Resistor-string tap code, positive half |
| fine_l | output | 7 | Left-half fine selector, one-hot |
| fine_r | output | 4 | Right-half fine selector, one-hot |
| result | output | 10 | Converted code |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can share a cycle: the `done` pulse and a new start. The end of a frame can also coincide with an attempted start. Back-to-back conversions drive `start` in the `done` cycle and expect a fresh frame with a cleared result. A start raised in the last cycle of a frame must leave the block idle one cycle after `done`. Both cases are judged from `phase`, from the popped scoreboard result, and from the absence of a stray `done`.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  localparam int FINE_BITS = 4;
  localparam int FL_TAPS = 7;
  localparam int FR_TAPS = 4;
  // left fine tap indices (offset in LSB)
  localparam int FL_M1 = 0;  // -1
  localparam int FL_Z  = 1;  //  0
  localparam int FL_P4 = 3;  // +4
  localparam int FL_P8 = 5;  // +8
  // right fine tap indices (offset subtracted)
  localparam int FR_Z  = 0;  //  0
  localparam int FR_M2 = 1;  // -2
  localparam int FR_M4 = 2;  // -4
  localparam int FR_M6 = 3;  // -6

  typedef struct packed {
    logic preamp;
    logic latch;
    logic rst;
  } cmp_strobe_t;
endpackage

// File: rtl/sar_frame_timer.sv
`timescale 1ns/1ps
module sar_frame_timer import sar_seq_pkg::*; #(
  parameter int NSLOT = 12,
  parameter int SUB   = 8,
  localparam int SW   = $clog2(NSLOT),
  localparam int TW   = $clog2(SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active_q,
  output logic [SW-1:0]    slot_q,
  output logic [TW-1:0]    tick_q,
  output logic             active_nx,
  output logic [SW-1:0]    slot_nx,
  output logic [TW-1:0]    tick_nx,
  output logic             accept,
  output logic             frame_end,
  output logic [NSLOT-1:0] phase_q,
  output cmp_strobe_t      strobe_q
);
  localparam int PRE = (SUB * 3) / 4;

  logic is_bit_nx;

  always_comb begin
    accept    = start && !active_q;
    frame_end = active_q && (slot_q == SW'(NSLOT-1)) && (tick_q == TW'(SUB-1));
    active_nx = active_q;
    slot_nx   = slot_q;
    tick_nx   = tick_q;
    if (accept) begin
      active_nx = 1'b1;
      slot_nx   = '0;
      tick_nx   = '0;
    end else if (active_q) begin
      if (tick_q == TW'(SUB-1)) begin
        tick_nx = '0;
        if (frame_end) begin
          active_nx = 1'b0;
          slot_nx   = '0;
        end else begin
          slot_nx = slot_q + 1'b1;
        end
      end else begin
        tick_nx = tick_q + 1'b1;
      end
    end
    is_bit_nx = active_nx && (slot_nx >= SW'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      tick_q   <= '0;
      phase_q  <= '0;
      strobe_q <= '0;
    end else begin
      active_q <= active_nx;
      slot_q   <= slot_nx;
      tick_q   <= tick_nx;
      for (int i = 0; i < NSLOT; i++) begin
        phase_q[i] <= active_nx && (slot_nx == SW'(i));
      end
      strobe_q.preamp <= is_bit_nx && (int'(tick_nx) < PRE);
      strobe_q.latch  <= is_bit_nx && (int'(tick_nx) >= PRE);
      strobe_q.rst    <= is_bit_nx && (tick_nx == TW'(SUB-1));
    end
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_q)); // R1
  AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> phase_q[slot_q]); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_q.preamp && strobe_q.latch)); // R9
  AST_RST_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q.rst |-> strobe_q.latch); // R9
endmodule

// File: rtl/sar_bit_store.sv
`timescale 1ns/1ps
module sar_bit_store #(
  parameter int NBITS = 10,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_en,
  input  logic [IW-1:0]    cap_idx,
  input  logic             cmp,
  input  logic             frame_end,
  output logic [NBITS-1:0] res_q,
  output logic [NBITS-1:0] res_nx,
  output logic             done_q
);
  always_comb begin
    res_nx = res_q;
    if (clear) res_nx = '0;
    else if (cap_en) res_nx[cap_idx] = cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_nx;
      done_q <= frame_end;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clear) |=> $stable(res_q)); // R11
endmodule

// File: rtl/sar_switch_map.sv
`timescale 1ns/1ps
module sar_switch_map import sar_seq_pkg::*; #(
  parameter int NBITS = 10,
  parameter int SW    = 4,
  parameter int TW    = 3,
  localparam int NC   = NBITS - FINE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_nx,
  input  logic [SW-1:0]      slot_nx,
  input  logic [TW-1:0]      tick_nx,
  input  logic [NBITS-1:0]   res_nx,
  output logic               samp_q,
  output logic               dac_q,
  output logic [NC-1:0]      tap_q,
  output logic [FL_TAPS-1:0] fl_q,
  output logic [FR_TAPS-1:0] fr_q
);
  logic          in_bits, samp_n, dac_n;
  logic [NC-1:0] c, t;
  logic          b6, b7, b8;
  int            j, li, ri;

  always_comb begin
    j       = int'(slot_nx) - 2;
    in_bits = active_nx && (slot_nx >= SW'(2));
    samp_n  = active_nx && (slot_nx == SW'(1));
    // break-before-make: first decision tick keeps the DAC detached
    dac_n   = in_bits && !((slot_nx == SW'(2)) && (tick_nx == '0));
    c       = res_nx[NBITS-1:FINE_BITS];
    b6      = res_nx[FINE_BITS-1];
    b7      = res_nx[FINE_BITS-2];
    b8      = res_nx[FINE_BITS-3];
    if (!in_bits)   t = NC'(1) << (NC-1);
    else if (j < NC) t = c | (NC'(1) << (NC-1-j));
    else            t = c;
    li = FL_Z;
    ri = FR_Z;
    if (in_bits) begin
      case (j - NC)
        0: begin li = FL_P4; ri = FR_M4; end
        1: begin li = b6 ? FL_P8 : FL_Z; ri = FR_M4; end
        2: begin li = b6 ? FL_P8 : FL_Z; ri = b7 ? FR_M6 : FR_M2; end
        3: begin li = FL_M1 + 4*int'(b6) + 2*int'(b8); ri = b7 ? FR_M6 : FR_M2; end
        default: begin li = FL_Z; ri = FR_Z; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      dac_q  <= 1'b0;
      tap_q  <= NC'(1) << (NC-1);
      fl_q   <= FL_TAPS'(1) << FL_Z;
      fr_q   <= FR_TAPS'(1) << FR_Z;
    end else begin
      samp_q <= samp_n;
      dac_q  <= dac_n;
      tap_q  <= t;
      fl_q   <= FL_TAPS'(1) << li;
      fr_q   <= FR_TAPS'(1) << ri;
    end
  end

  AST_SAMP_DAC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_q && dac_q)); // R3
  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_q) |-> !dac_q); // R3
  AST_FINE_L_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(fl_q)); // R5
  AST_FINE_R_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(fr_q)); // R7
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl import sar_seq_pkg::*; #(
  parameter int NBITS = 10,
  parameter int SUB   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      cmp,
  output logic [NBITS+1:0]          phase,
  output logic                      preamp,
  output logic                      latch,
  output logic                      cmp_rst,
  output logic                      samp_en,
  output logic                      dac_en,
  output logic [NBITS-FINE_BITS-1:0] coarse_tap,
  output logic [FL_TAPS-1:0]        fine_l,
  output logic [FR_TAPS-1:0]        fine_r,
  output logic [NBITS-1:0]          result,
  output logic                      done
);
  localparam int NSLOT = NBITS + 2;
  localparam int SW    = $clog2(NSLOT);
  localparam int TW    = $clog2(SUB);
  localparam int IW    = $clog2(NBITS);

  logic          active_q, active_nx, accept, frame_end, cap_en;
  logic [SW-1:0] slot_q, slot_nx;
  logic [TW-1:0] tick_q, tick_nx;
  logic [IW-1:0] cap_idx;
  logic [NBITS-1:0] res_nx;
  cmp_strobe_t   strb;

  sar_frame_timer #(.NSLOT(NSLOT), .SUB(SUB)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active_q(active_q), .slot_q(slot_q), .tick_q(tick_q),
    .active_nx(active_nx), .slot_nx(slot_nx), .tick_nx(tick_nx),
    .accept(accept), .frame_end(frame_end),
    .phase_q(phase), .strobe_q(strb)
  );

  assign cap_en  = active_q && (slot_q >= SW'(2)) && (tick_q == TW'(SUB-1));
  assign cap_idx = IW'(NBITS + 1 - int'(slot_q));

  sar_bit_store #(.NBITS(NBITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap_en(cap_en),
    .cap_idx(cap_idx), .cmp(cmp), .frame_end(frame_end),
    .res_q(result), .res_nx(res_nx), .done_q(done)
  );

  sar_switch_map #(.NBITS(NBITS), .SW(SW), .TW(TW)) u_map (
    .clk(clk), .rst_n(rst_n), .active_nx(active_nx), .slot_nx(slot_nx),
    .tick_nx(tick_nx), .res_nx(res_nx),
    .samp_q(samp_en), .dac_q(dac_en), .tap_q(coarse_tap),
    .fl_q(fine_l), .fr_q(fine_r)
  );

  assign preamp  = strb.preamp;
  assign latch   = strb.latch;
  assign cmp_rst = strb.rst;

  AST_CAPTURE_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (latch && cmp_rst)); // R10
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !frame_end) |=> active_q); // R12
endmodule

// File: tb/sar_seq_ctrl_test.sv
`timescale 1ns/1ps
module sar_seq_ctrl_test;
  localparam int NB = 10, SUB = 8, NSLOT = 12, FRAME = NSLOT * SUB;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp = 1'b0;
  logic [NSLOT-1:0] phase;
  logic preamp, latch, cmp_rst, samp_en, dac_en, done;
  logic [5:0] coarse_tap;
  logic [6:0] fine_l;
  logic [3:0] fine_r;
  logic [NB-1:0] result;

  int x_in = 0;
  int n_chk = 0, n_fail = 0;
  int expq[$];

  always #10 clk = ~clk;

  sar_seq_ctrl #(.NBITS(NB), .SUB(SUB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp), .phase(phase),
    .preamp(preamp), .latch(latch), .cmp_rst(cmp_rst), .samp_en(samp_en),
    .dac_en(dac_en), .coarse_tap(coarse_tap), .fine_l(fine_l),
    .fine_r(fine_r), .result(result), .done(done)
  );

  function automatic int oh_idx(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int lval(int idx);
    case (idx)
      0: return -1; 1: return 0; 2: return 1; 3: return 4;
      4: return 7;  5: return 8; 6: return 9; default: return 999;
    endcase
  endfunction

  function automatic int rval(int idx);
    return (idx >= 0 && idx < 4) ? -2 * idx : 999;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ideal comparator closing the loop through the switch enables (R10)
  always @(negedge clk) begin
    int lvl;
    lvl = 16 * int'(coarse_tap) + lval(oh_idx({1'b0, fine_l})) - rval(oh_idx({4'b0, fine_r}));
    cmp = dac_en ? (x_in >= lvl) : 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) check(1'b0, "R12 unexpected done", 1, 0);
      else begin
        int e;
        e = expq.pop_front();
        check(int'(result) == e, "R10 result", int'(result), e);
      end
    end
  end

  // driver: starts at the current negedge, returns at the done cycle
  task automatic run_frame(int x, int inj);
    int er[13], ac[13], ex[13];
    for (int i = 0; i < 13; i++) begin er[i] = 0; ac[i] = 0; ex[i] = 0; end
    x_in = x;
    expq.push_back(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(result == '0, "R10 clear on start", int'(result), 0);
    for (int c = 0; c < FRAME; c++) begin
      int s, t, j, ec, el, erx, b6, b7, b8;
      s = c / SUB; t = c % SUB; j = s - 2;
      b6 = (x >> 3) & 1; b7 = (x >> 2) & 1; b8 = (x >> 1) & 1;
      if (phase != (12'(1) << s)) begin er[1]++; ac[1] = int'(phase); ex[1] = 1 << s; end
      if (samp_en != (s == 1)) begin er[2]++; ac[2] = samp_en; ex[2] = (s == 1); end
      if (dac_en != (s >= 2 && !(s == 2 && t == 0))) begin er[3]++; ac[3] = dac_en; ex[3] = c; end
      if (s < 2) ec = 32;
      else if (j < 6) ec = ((x >> 4) & ~((1 << (6 - j)) - 1)) | (1 << (5 - j));
      else ec = x >> 4;
      if (int'(coarse_tap) != ec) begin er[4]++; ac[4] = coarse_tap; ex[4] = ec; end
      el = 1; erx = 0;
      if (j == 6) begin el = 3; erx = 2; end
      if (j == 7) begin el = b6 ? 5 : 1; erx = 2; end
      if (j == 8) begin el = b6 ? 5 : 1; erx = b7 ? 3 : 1; end
      if (j == 9) begin el = 4 * b6 + 2 * b8; erx = b7 ? 3 : 1; end
      if (j <= 6 && (oh_idx({1'b0, fine_l}) != el || oh_idx({4'b0, fine_r}) != erx)) begin
        if (s < 2) begin er[2]++; ac[2] = fine_l; ex[2] = 2; end
        else begin er[5]++; ac[5] = oh_idx({1'b0, fine_l}); ex[5] = el; end
      end
      if (j == 7 && (oh_idx({1'b0, fine_l}) != el || oh_idx({4'b0, fine_r}) != erx)) begin
        er[6]++; ac[6] = oh_idx({1'b0, fine_l}); ex[6] = el; end
      if (j == 8 && (oh_idx({1'b0, fine_l}) != el || oh_idx({4'b0, fine_r}) != erx)) begin
        er[7]++; ac[7] = oh_idx({4'b0, fine_r}); ex[7] = erx; end
      if (j == 9 && (oh_idx({1'b0, fine_l}) != el || oh_idx({4'b0, fine_r}) != erx)) begin
        er[8]++; ac[8] = oh_idx({1'b0, fine_l}); ex[8] = el; end
      if (preamp != (s >= 2 && t < 6) || latch != (s >= 2 && t >= 6) ||
          cmp_rst != (s >= 2 && t == 7)) begin
        er[9]++; ac[9] = {preamp, latch, cmp_rst}; ex[9] = c; end
      if (done) begin er[11]++; ac[11] = 1; ex[11] = 0; end
      start = (c == inj);
      @(negedge clk);
    end
    start = 1'b0;
    check(er[1] == 0, "R1 phase strobes", ac[1], ex[1]);
    check(er[2] == 0, "R2 sampling and idle taps", ac[2], ex[2]);
    check(er[3] == 0, "R3 break-before-make", ac[3], ex[3]);
    check(er[4] == 0, "R4 coarse trial", ac[4], ex[4]);
    check(er[5] == 0, "R5 fine first step", ac[5], ex[5]);
    check(er[6] == 0, "R6 left move", ac[6], ex[6]);
    check(er[7] == 0, "R7 right move", ac[7], ex[7]);
    check(er[8] == 0, "R8 final left move", ac[8], ex[8]);
    check(er[9] == 0, "R9 comparator strobes", ac[9], ex[9]);
    check(er[11] == 0, "R11 no early done", ac[11], ex[11]);
    check(done == 1'b1, "R11 done timing", done, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int xs[12];
    xs = '{0, 1023, 512, 511, 682, 341, 8, 15, 16, 1000, 3, 1020};
    repeat (3) @(negedge clk);
    // reset state (R2)
    check(phase == '0 && done == 1'b0 && samp_en == 1'b0 && dac_en == 1'b0,
          "R2 reset outputs", {phase, done}, 0);
    check(coarse_tap == 6'd32 && fine_l == 7'b0000010 && fine_r == 4'b0001,
          "R2 reset taps", coarse_tap, 32);
    check(result == '0, "R10 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // back-to-back frames, each start lands in the done cycle (R12)
    foreach (xs[i]) run_frame(xs[i], -1);
    for (int k = 0; k < 6; k++) run_frame((k * 397 + 123) % 1024, -1);
    // start mid-frame is ignored (R12)
    run_frame(300, 40);
    @(negedge clk);
    check(phase == '0 && done == 1'b0, "R12 mid-frame start ignored", int'(phase), 0);
    // start in the final frame cycle is ignored (R12)
    run_frame(777, FRAME - 1);
    @(negedge clk);
    check(phase == '0, "R12 last-cycle start ignored", int'(phase), 0);
    check(done == 1'b0, "R11 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    check(int'(result) == 777 && done == 1'b0, "R11 result held", int'(result), 777);
    check(coarse_tap == 6'd32 && fine_l == 7'b0000010 && fine_r == 4'b0001 && samp_en == 1'b0,
          "R2 idle taps", coarse_tap, 32);
    check(expq.size() == 0, "R11 all frames completed", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule